// File: doc/BRIEF.md
# Signed Offset Trim Register

This block holds the factory offset-trim code of a capacitive sensing front end and drives the switches of two binary-weighted trim capacitor arrays. One array sits across each of the two sense capacitors. The trim code is signed. Its magnitude is routed to the array on the side selected by the sign, and the opposite array is held at zero, so the offset can be cancelled in either direction.

A new code is shifted in over a three-wire serial port (clock, data and load strobe). All three wires are sampled by the system clock. A load is committed to the shadow register that drives the switches only at a sampling-period boundary, so switch settings never change in the middle of a conversion cycle. After reset, both arrays stay at zero until one word has been restored from a nonvolatile-memory read port. A done flag reports that the restore has completed.

The block also drives two control lines for the trim network. The first closes the reset switches of the network's floating nodes during the feedback phase. The second grounds the arrays during the zero phase.

Top module: `offset_trim_reg`

## Requirements
- R1: On each rising edge of `ser_clk_i` (detected in the `clk` domain), `ser_dat_i` is shifted into a 5-bit shift register MSB first. Bit 4 of the resulting word is the sign and bits 3:0 are the magnitude.
- R2: With a committed sign of 0, `arr_pos_o` equals the magnitude and `arr_neg_o` is 0. With a sign of 1, `arr_neg_o` equals the magnitude and `arr_pos_o` is 0. A magnitude of 0 gives zero on both arrays whatever the sign.
- R3: A rising edge of `ser_ld_i` arms a pending load. The shift-register contents are copied to the outputs only on the first clock with `bnd_i` high at or after that edge, and they appear in the cycle after that clock. The arrays do not change at any other time except at the restore.
- R4: While `rst_n` is low, both arrays are 0, `trim_done_o` is 0 and `nvm_rd_o` is 1.
- R5: While `trim_done_o` is 0, `nvm_rd_o` is 1. A clock with `nvm_vld_i` high loads `nvm_word_i` (same 5-bit layout as in R1), and from the next cycle `trim_done_o` is 1 and `nvm_rd_o` is 0. `trim_done_o` then stays high until reset, and later `nvm_vld_i` pulses have no effect.
- R6: A serial load armed or reaching a boundary before `trim_done_o` is high is discarded and never reaches the arrays.
- R7: `node_rst_o` is high whenever `ph_fb_i` is high or `trim_done_o` is low, and low otherwise.
- R8: `arr_gnd_o` follows `ph_zero_i`.
- R9: `arr_pos_o` and `arr_neg_o` are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_i | input | 1 | Load strobe, rising edge arms a commit |
| bnd_i | input | 1 | Sampling-period boundary pulse |
| ph_fb_i | input | 1 | Feedback phase active |
| ph_zero_i | input | 1 | Zero phase active |
| nvm_vld_i | input | 1 | Nonvolatile word valid |
| nvm_word_i | input | 5 | Stored trim word: sign in bit 4, magnitude in bits 3:0 |
| nvm_rd_o | output | 1 | Restore request |
| trim_done_o | output | 1 | Restore completed |
| arr_pos_o | output | 4 | Switch code of the positive-side array |
| arr_neg_o | output | 4 | Switch code of the negative-side array |
| node_rst_o | output | 1 | Closes the floating-node reset switches |
| arr_gnd_o | output | 1 | Grounds the trim arrays |

## Verification
Two events can fall on the same clock: the rising edge of the load strobe and the period boundary. The bench raises both on one clock and expects the new code in the very next cycle, not one boundary later. It also separates a strobe from its boundary by several clocks, with more serial shifting in between, and checks that the arrays hold their old code until the boundary. The code that then lands must be the shift-register contents at the boundary.

// File: rtl/offset_trim_reg.sv
module offset_trim_reg #(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_ld_i,
  input  logic             bnd_i,
  input  logic             ph_fb_i,
  input  logic             ph_zero_i,
  input  logic             nvm_vld_i,
  input  logic [MAG_W:0]   nvm_word_i,
  output logic             nvm_rd_o,
  output logic             trim_done_o,
  output logic [MAG_W-1:0] arr_pos_o,
  output logic [MAG_W-1:0] arr_neg_o,
  output logic             node_rst_o,
  output logic             arr_gnd_o
);
  localparam int W = MAG_W + 1;

  logic [W-1:0] shift_q, shadow_q;
  logic         sclk_q, sld_q, pend_q, done_q;
  logic         sclk_rise, sld_rise, commit;

  assign sclk_rise = ser_clk_i & ~sclk_q;
  assign sld_rise  = ser_ld_i & ~sld_q;
  assign commit    = done_q & bnd_i & (pend_q | sld_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      sld_q    <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      shift_q  <= '0;
      shadow_q <= '0;
    end else begin
      sclk_q <= ser_clk_i;
      sld_q  <= ser_ld_i;
      if (sclk_rise)
        shift_q <= {shift_q[W-2:0], ser_dat_i};
      pend_q <= done_q & ~commit & (pend_q | sld_rise);
      if (!done_q && nvm_vld_i) begin
        shadow_q <= nvm_word_i;
        done_q   <= 1'b1;
      end else if (commit) begin
        shadow_q <= shift_q;
      end
    end
  end

  logic             sgn;
  logic [MAG_W-1:0] mag;
  assign sgn = shadow_q[W-1];
  assign mag = done_q ? shadow_q[MAG_W-1:0] : '0;

  assign arr_pos_o   = sgn ? '0 : mag;
  assign arr_neg_o   = sgn ? mag : '0;
  assign trim_done_o = done_q;
  assign nvm_rd_o    = ~done_q;
  assign node_rst_o  = ph_fb_i | ~done_q;
  assign arr_gnd_o   = ph_zero_i;
endmodule

// File: rtl/offset_trim_chk.sv
module offset_trim_chk #(
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bnd_i,
  input logic             ph_fb_i,
  input logic             trim_done_o,
  input logic [MAG_W-1:0] arr_pos_o,
  input logic [MAG_W-1:0] arr_neg_o,
  input logic             node_rst_o
);
  // R9
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|arr_pos_o) && (|arr_neg_o)));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_done_o |-> (arr_pos_o == '0 && arr_neg_o == '0));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trim_done_o |=> trim_done_o);

  // R3
  change_at_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(arr_pos_o) || !$stable(arr_neg_o)) |-> ($past(bnd_i) || $rose(trim_done_o)));

  // R7
  node_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_fb_i || !trim_done_o) |-> node_rst_o);
endmodule

bind offset_trim_reg offset_trim_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .ph_fb_i(ph_fb_i),
  .trim_done_o(trim_done_o), .arr_pos_o(arr_pos_o), .arr_neg_o(arr_neg_o),
  .node_rst_o(node_rst_o)
);

// File: tb/test_offset_trim_reg.sv
module test_offset_trim_reg;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, sld = 0, bnd = 0, pfb = 0, pzero = 0, nvld = 0;
  logic [4:0] nword = '0;
  logic nrd, done, nrst, agnd;
  logic [3:0] apos, aneg;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  offset_trim_reg i_offset_trim_reg (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .bnd_i(bnd), .ph_fb_i(pfb), .ph_zero_i(pzero), .nvm_vld_i(nvld), .nvm_word_i(nword),
    .nvm_rd_o(nrd), .trim_done_o(done), .arr_pos_o(apos), .arr_neg_o(aneg),
    .node_rst_o(nrst), .arr_gnd_o(agnd));

  // {word, expected pos, expected neg}
  localparam logic [12:0] VEC [6] = '{
    {5'b01111, 4'd15, 4'd0}, {5'b11010, 4'd0, 4'd10}, {5'b10000, 4'd0, 4'd0},
    {5'b00001, 4'd1, 4'd0},  {5'b11111, 4'd0, 4'd15}, {5'b00000, 4'd0, 4'd0}};

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [4:0] w);
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk); sdat = w[i]; sclk = 1;
      @(negedge clk); sclk = 0;
    end
  endtask

  task automatic pulse_ld;
    @(negedge clk); sld = 1;
    @(negedge clk); sld = 0;
  endtask

  task automatic pulse_bnd;
    @(negedge clk); bnd = 1;
    @(negedge clk); bnd = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4
    chk({apos, aneg}, 8'h00, "R4 arrays in reset");
    chk({done, nrd}, 2'b01, "R4 done/rd in reset");
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    // R6: serial load before restore discarded
    shift_word(5'b00111); pulse_ld; pulse_bnd;
    chk({apos, aneg}, 8'h00, "R6 load before done");
    // R7 before done
    chk(nrst, 1'b1, "R7 node reset while not done");
    // R5 restore
    @(negedge clk); nword = 5'b10101; nvld = 1;
    @(negedge clk); nvld = 0; nword = 5'b00011;
    chk({done, nrd}, 2'b10, "R5 done after restore");
    chk({apos, aneg}, {4'd0, 4'd5}, "R5 restored word");
    @(negedge clk); nvld = 1;
    @(negedge clk); nvld = 0;
    chk({apos, aneg}, {4'd0, 4'd5}, "R5 late valid ignored");
    pulse_bnd;
    chk({apos, aneg}, {4'd0, 4'd5}, "R6 discarded load stays dropped");
    // R1 R2 R3 table
    foreach (VEC[k]) begin
      shift_word(VEC[k][12:8]);
      pulse_ld;
      repeat (2) @(negedge clk);
      chk({apos, aneg}, (k == 0) ? {4'd0, 4'd5} : {VEC[k-1][7:4], VEC[k-1][3:0]},
          "R3 hold until boundary");
      pulse_bnd;
      chk({apos, aneg}, VEC[k][7:0], "R1 R2 committed word");
    end
    // R3 strobe rise and boundary on the same clock
    shift_word(5'b00110);
    @(negedge clk); sld = 1; bnd = 1;
    @(negedge clk); sld = 0; bnd = 0;
    chk({apos, aneg}, {4'd6, 4'd0}, "R3 strobe with boundary");
    // R3 shifting after strobe: boundary takes current shift contents
    shift_word(5'b01001); pulse_ld; shift_word(5'b11100);
    chk({apos, aneg}, {4'd6, 4'd0}, "R3 no change before boundary");
    pulse_bnd;
    chk({apos, aneg}, {4'd0, 4'd12}, "R3 boundary copies shift register");
    // R3 boundary without strobe
    shift_word(5'b00010); pulse_bnd;
    chk({apos, aneg}, {4'd0, 4'd12}, "R3 boundary without strobe ignored");
    // R7 R8 phases
    @(negedge clk); pfb = 1; pzero = 0;
    #1 chk({nrst, agnd}, 2'b10, "R7 feedback phase");
    @(negedge clk); pfb = 0; pzero = 1;
    #1 chk({nrst, agnd}, 2'b01, "R8 zero phase");
    @(negedge clk); pzero = 0;
    #1 chk({nrst, agnd}, 2'b00, "R7 R8 idle");
    // R4 reset again clears
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk({done, nrd, apos, aneg}, {2'b01, 8'h00}, "R4 reset clears");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule